// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Arbiter

This block decides which of up to fifteen maskable request lines an 8-bit processor core should service next. Each line has an enable bit and a level bit that places it in the high or the low group. A master enable gates every line at once. At each instruction boundary that the core reports, the block picks one eligible request. It then raises a one-cycle take request toward the core's sequencer and presents the handler address.

Nesting has two levels. A low-group handler can be preempted by a high-group request. Nothing preempts a high-group handler, and no request preempts a handler of its own group. Two in-service bits record which levels are active, and a return pulse from the core retires the highest active one. The boundary that completes a return never vectors, so at least one more instruction runs first. Each request line is the OR of several peripheral flags. Lines chosen by a parameter also get a clear pulse when they are vectored; the other lines keep their flag until software clears it.

Top module: `intc_two_level`

## Requirements
- R1: After reset, take_o is 0, vec_o is 0x0000, clr_o is all zeros and in_service_o is 2'b00.
- R2: Taking source n drives vec_o to 0x0003 + 8*n, so source 0 gives 0x0003 and source 14 gives 0x0073. take_o is high for the single cycle after the clock edge that sampled the boundary.
- R3: When several eligible sources share a level, the lowest source index wins.
- R4: A source whose enable bit is 0 is never taken. While the master enable is 0, no source is taken. Neither case clears the request, which is taken at a later boundary once it is enabled.
- R5: A priority bit of 1 puts a source in the high group and 0 puts it in the low group. An eligible high-group source beats any low-group source, whatever its index.
- R6: A request is never taken while a handler of its own level or a higher level is in service. A high-group request is taken while only a low-group handler is active.
- R7: in_service_o bit 1 marks the high level and bit 0 the low level. A take sets the bit of the vectored level. A return clears bit 1 if it is set, and bit 0 otherwise.
- R8: A boundary that arrives together with reti_i never produces a take. The next boundary may produce one.
- R9: Takes happen only at boundaries. A request that appears between boundaries waits, with take_o low, until insn_done_i is next high.
- R10: In the take cycle, clr_o pulses only the bit of the vectored source, and only when that source is in the auto-clear set (sources 0 to 7 by default). A take of any other source leaves clr_o at zero.
- R11: The request of source n is the OR of flag_i bits n*2 and n*2+1. Either flag alone raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_i | input | 30 | Peripheral flags, two per source, bit n*2+k |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 15 | Enable bits, one per source |
| pri_we_i | input | 1 | Write strobe for the level register |
| pri_wdata_i | input | 15 | Level bits, 1 = high group |
| gie_we_i | input | 1 | Write strobe for the master enable |
| gie_wdata_i | input | 1 | Master enable value |
| insn_done_i | input | 1 | Instruction boundary from the core |
| reti_i | input | 1 | Return-from-interrupt completes this cycle |
| take_o | output | 1 | One-cycle take-interrupt request |
| vec_o | output | 16 | Handler address of the last take |
| clr_o | output | 15 | Auto-clear pulse toward the source's peripheral |
| in_service_o | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
The collision that matters is a return retiring a level at the same boundary where a request becomes eligible because that level was freed. The bench sets up a low handler with a high handler nested inside it. It keeps a second high request pending, then signals a return. It checks that the return boundary drops in_service_o to the low bit alone with take_o held low. It then checks that the very next boundary vectors to the waiting request. A second collision comes from the take itself: the auto-clear pulse and the vector must appear in the same cycle, and the bench checks both together.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } intc_lvl_e;

   // handler address of a source from base and spacing
   function automatic int unsigned intc_vec_addr(input int unsigned base,
                                                 input int unsigned stride,
                                                 input int unsigned idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/intc_flag_merge.sv
module intc_flag_merge #(
   parameter int NUM_SRC   = 15,
   parameter int SUB_FLAGS = 2,
   localparam int FLAG_W   = NUM_SRC * SUB_FLAGS
) (
   input  logic [FLAG_W-1:0]  flag_i,
   output logic [NUM_SRC-1:0] req_o
);

   if (SUB_FLAGS < 1) begin : g_bad_sub
      $error("SUB_FLAGS must be at least 1");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (SUB_FLAGS == 1) begin : g_single
         assign req_o[s] = flag_i[s];
      end else begin : g_multi
         assign req_o[s] = |flag_i[s*SUB_FLAGS +: SUB_FLAGS];
      end
   end

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int N     = 15,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   // lowest index has the strongest natural priority
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/intc_level_track.sv
module intc_level_track (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       take_i,
   input  logic       take_hi_i,
   input  logic       ret_i,
   output logic [1:0] isv_o
);

   logic [1:0] isv_q;
   logic [1:0] isv_d;

   always_comb begin
      isv_d = isv_q;
      if (take_i) begin
         isv_d[take_hi_i ? 1 : 0] = 1'b1;
      end else if (ret_i) begin
         if (isv_q[1]) isv_d[1] = 1'b0;
         else          isv_d[0] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) isv_q <= 2'b00;
      else         isv_q <= isv_d;
   end

   assign isv_o = isv_q;

endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
   parameter int          NUM_SRC       = 15,
   parameter int          SUB_FLAGS     = 2,
   parameter int          VEC_W         = 16,
   parameter int          VEC_BASE      = 3,
   parameter int          VEC_STRIDE    = 8,
   parameter logic [31:0] AUTO_CLR_MASK = 32'h0000_00FF,
   localparam int         FLAG_W        = NUM_SRC * SUB_FLAGS,
   localparam int         IDX_W         = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [FLAG_W-1:0]  flag_i,
   input  logic               en_we_i,
   input  logic [NUM_SRC-1:0] en_wdata_i,
   input  logic               pri_we_i,
   input  logic [NUM_SRC-1:0] pri_wdata_i,
   input  logic               gie_we_i,
   input  logic               gie_wdata_i,
   input  logic               insn_done_i,
   input  logic               reti_i,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [1:0]         in_service_o
);
   import intc_pkg::*;

   localparam int LAST_VEC = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);
   localparam logic [NUM_SRC-1:0] AUTO_V = AUTO_CLR_MASK[NUM_SRC-1:0];

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_n
      $error("NUM_SRC must lie in 2..32");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("VEC_STRIDE must be positive");
   end
   if (VEC_W < 32 && LAST_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("last vector does not fit in VEC_W bits");
   end

   logic [NUM_SRC-1:0] en_q, pri_q, req;
   logic               gie_q;
   logic [NUM_SRC-1:0] cand_hi, cand_lo;
   logic               any_hi, any_lo;
   logic [IDX_W-1:0]   idx_hi, idx_lo, sel_idx;
   logic               can_hi, can_lo, take_d, sel_hi;
   logic [1:0]         isv;
   intc_lvl_e          sel_lvl;

   logic               take_q;
   logic [VEC_W-1:0]   vec_q;
   logic [NUM_SRC-1:0] clr_q;

   // configuration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         pri_q <= '0;
         gie_q <= 1'b0;
      end else begin
         if (en_we_i)  en_q  <= en_wdata_i;
         if (pri_we_i) pri_q <= pri_wdata_i;
         if (gie_we_i) gie_q <= gie_wdata_i;
      end
   end

   intc_flag_merge #(
      .NUM_SRC  (NUM_SRC),
      .SUB_FLAGS(SUB_FLAGS)
   ) merge_i (
      .flag_i(flag_i),
      .req_o (req)
   );

   assign cand_hi = req & en_q &  pri_q & {NUM_SRC{gie_q}};
   assign cand_lo = req & en_q & ~pri_q & {NUM_SRC{gie_q}};

   intc_prio_pick #(.N(NUM_SRC)) pick_hi_i (
      .req_i(cand_hi),
      .any_o(any_hi),
      .idx_o(idx_hi)
   );

   intc_prio_pick #(.N(NUM_SRC)) pick_lo_i (
      .req_i(cand_lo),
      .any_o(any_lo),
      .idx_o(idx_lo)
   );

   // a level may vector only when it and every level above it are idle
   assign can_hi  = any_hi && !isv[1];
   assign can_lo  = any_lo && (isv == 2'b00);
   assign take_d  = insn_done_i && !reti_i && (can_hi || can_lo);
   assign sel_lvl = can_hi ? LVL_HI : LVL_LO;
   assign sel_hi  = (sel_lvl == LVL_HI);
   assign sel_idx = sel_hi ? idx_hi : idx_lo;

   intc_level_track track_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (take_d),
      .take_hi_i(sel_hi),
      .ret_i    (reti_i),
      .isv_o    (isv)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         clr_q  <= '0;
      end else begin
         take_q <= take_d;
         clr_q  <= '0;
         if (take_d) begin
            vec_q <= VEC_W'(intc_vec_addr(VEC_BASE, VEC_STRIDE, 32'(sel_idx)));
            if (AUTO_V[sel_idx]) clr_q <= NUM_SRC'(1) << sel_idx;
         end
      end
   end

   assign take_o       = take_q;
   assign vec_o        = vec_q;
   assign clr_o        = clr_q;
   assign in_service_o = isv;

endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
   parameter int NUM_SRC    = 15,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               insn_done_i,
   input logic               reti_i,
   input logic               take_o,
   input logic [VEC_W-1:0]   vec_o,
   input logic [NUM_SRC-1:0] clr_o,
   input logic [1:0]         in_service_o
);

   // R9
   take_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> $past(insn_done_i));

   // R8
   no_take_after_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reti_i |=> !take_o);

   // R6
   take_adds_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ($countones(in_service_o) == $countones($past(in_service_o)) + 1));

   // R7
   ret_drops_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && in_service_o != 2'b00) |=>
         ($countones(in_service_o) == $countones($past(in_service_o)) - 1));

   // R10
   clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clr_o));

   // R10
   clr_with_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_o != '0) |-> take_o);

   // R2
   vec_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ((32'(vec_o) - VEC_BASE) % VEC_STRIDE == 0));

endmodule

bind intc_two_level intc_two_level_chk #(
   .NUM_SRC   (NUM_SRC),
   .VEC_W     (VEC_W),
   .VEC_BASE  (VEC_BASE),
   .VEC_STRIDE(VEC_STRIDE)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .insn_done_i (insn_done_i),
   .reti_i      (reti_i),
   .take_o      (take_o),
   .vec_o       (vec_o),
   .clr_o       (clr_o),
   .in_service_o(in_service_o)
);

// File: tb/intc_two_level_tb_top.sv
module intc_two_level_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] flag = '0;
   logic        en_we = 0, pri_we = 0, gie_we = 0, gie_wd = 0;
   logic [14:0] en_wd = '0, pri_wd = '0;
   logic        insn_done = 0, reti = 0;
   logic        take;
   logic [15:0] vec;
   logic [14:0] clr;
   logic [1:0]  isv;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   intc_two_level dut_i (
      .clk_i(clk), .rst_ni(rst_n), .flag_i(flag),
      .en_we_i(en_we), .en_wdata_i(en_wd),
      .pri_we_i(pri_we), .pri_wdata_i(pri_wd),
      .gie_we_i(gie_we), .gie_wdata_i(gie_wd),
      .insn_done_i(insn_done), .reti_i(reti),
      .take_o(take), .vec_o(vec), .clr_o(clr), .in_service_o(isv)
   );

   typedef struct packed {
      logic [14:0] en;
      logic [14:0] pri;
      logic [29:0] flags;
      logic        tk;
      logic [3:0]  src;
      logic [15:0] vec;
   } ent_t;

   localparam ent_t TBL [8] = '{
      '{15'h7FFF, 15'h0000, 30'h0000400,  1'b1, 4'd5,  16'h002B}, // R2
      '{15'h7FFF, 15'h0000, 30'h0040040,  1'b1, 4'd3,  16'h001B}, // R3
      '{15'h0200, 15'h0000, 30'h0040040,  1'b1, 4'd9,  16'h004B}, // R4
      '{15'h7FFF, 15'h1000, 30'h2000010,  1'b1, 4'd12, 16'h0063}, // R5 R11
      '{15'h0000, 15'h0000, 30'h0000400,  1'b0, 4'd0,  16'h0000}, // R4
      '{15'h7FFF, 15'h0000, 30'h0000002,  1'b1, 4'd0,  16'h0003}, // R2 R11
      '{15'h7FFF, 15'h0000, 30'h10000000, 1'b1, 4'd14, 16'h0073}, // R2
      '{15'h7FFF, 15'h0180, 30'h0014000,  1'b1, 4'd7,  16'h003B}  // R3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [14:0] e, input logic [14:0] p, input logic g);
      @(negedge clk);
      en_we = 1; en_wd = e; pri_we = 1; pri_wd = p; gie_we = 1; gie_wd = g;
      @(negedge clk);
      en_we = 0; pri_we = 0; gie_we = 0;
   endtask

   // one boundary; outputs are sampled at the following falling edge
   task automatic bnd(input logic r);
      insn_done = 1; reti = r;
      @(negedge clk);
      insn_done = 0; reti = 0;
   endtask

   function automatic logic [14:0] exp_clr(input logic tk, input logic [3:0] s);
      return (tk && s < 8) ? (15'h1 << s) : 15'h0;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 take", take, 0);
      chk("R1 vec", vec, 16'h0000);
      chk("R1 clr", clr, 0);
      chk("R1 isv", isv, 0);
      rst_n = 1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         wr(TBL[i].en, TBL[i].pri, 1'b1);
         flag = TBL[i].flags;
         @(negedge clk);
         bnd(0);
         chk($sformatf("R2/R3/R4/R5 take row%0d", i), take, TBL[i].tk);
         if (TBL[i].tk) begin
            chk($sformatf("R2 vec row%0d", i), vec, TBL[i].vec);
            chk($sformatf("R7 isv row%0d", i), isv,
                TBL[i].pri[TBL[i].src] ? 2'b10 : 2'b01);
         end
         chk($sformatf("R10 clr row%0d", i), clr, exp_clr(TBL[i].tk, TBL[i].src));
         flag = '0;
         if (TBL[i].tk) bnd(1);
         chk($sformatf("R7 isv idle row%0d", i), isv, 0);
      end

      // R4 master enable masks, request survives
      wr(15'h7FFF, 15'h0000, 1'b0);
      flag = 30'h400;
      bnd(0);
      chk("R4 gie off take", take, 0);
      chk("R4 gie off isv", isv, 0);
      wr(15'h7FFF, 15'h0000, 1'b1);
      bnd(0);
      chk("R4 gie on take", take, 1);
      chk("R4 gie on vec", vec, 16'h002B);
      flag = '0;
      bnd(1);

      // R9 request between boundaries waits
      flag = 30'h10;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R9 no boundary", take, 0);
      end
      bnd(0);
      chk("R9 at boundary take", take, 1);
      chk("R9 at boundary vec", vec, 16'h0013);
      flag = '0;
      bnd(1);

      // R6/R7/R8 nesting: low src4, high src10 and src6
      wr(15'h7FFF, 15'h0440, 1'b1);
      flag = 30'h100;
      bnd(0);
      chk("R6 low take", take, 1);
      chk("R2 low vec", vec, 16'h0023);
      chk("R10 auto clr src4", clr, 15'h0010);
      chk("R7 low isv", isv, 2'b01);
      flag = 30'h4;
      bnd(0);
      chk("R6 low blocks low", take, 0);
      flag = 30'h100004;
      bnd(0);
      chk("R6 high preempts", take, 1);
      chk("R6 high vec", vec, 16'h0053);
      chk("R10 no clr src10", clr, 0);
      chk("R7 both isv", isv, 2'b11);
      flag = 30'h1004;
      bnd(0);
      chk("R6 high blocks high", take, 0);
      bnd(1);
      chk("R8 return boundary", take, 0);
      chk("R7 return clears high", isv, 2'b01);
      bnd(0);
      chk("R8 next boundary take", take, 1);
      chk("R8 next boundary vec", vec, 16'h0033);
      chk("R10 auto clr src6", clr, 15'h0040);
      flag = 30'h4;
      bnd(1);
      chk("R7 second return", isv, 2'b01);
      flag = '0;
      bnd(1);
      chk("R7 third return", isv, 2'b00);

      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule